// File: doc/BRIEF.md
# Word-Paced SPI Master with Register Port

This block is a single-channel SPI master that a processor drives through a small 16-bit register port. The port has three registers: a data register, a control word and a status word. Software sets the word size, clock polarity, clock phase and a clock divider in the control word. It then writes one word to the data register, and the engine shifts that word out on MOSI, most significant bit first, while it shifts in the same number of bits from MISO. When the word is complete, the received word sits in the data register and a receive-full flag is raised.

Transfers are paced one word at a time. Software writes the next word only when the engine is idle, and it reads the data register when the receive-full flag is set. A level-sensitive interrupt output reports two conditions, each with its own enable: a received word is waiting, or the engine is enabled and ready to accept a word. Chip selects are outside the block.

The serial clock is the system clock divided by 2·(N+1), where N is a 7-bit field of the control word. A synchronous reset leaves the engine disabled in phase 0 and polarity 0, with N = 0.

Top module: `spi_word_master`

## Requirements
- R1: After reset, the control word (offset 2) and the status word (offset 4) read 0, `sclk` is 0 and `irq` is 0.
- R2: A write to offset 0 starts one word transfer only when control bit 0 (enable) is 1 and status bit 0 (busy) is 0. Busy is 1 from the clock edge that accepts the write until the end of the word. A data write made while disabled or while busy has no effect.
- R3: Control bit 2 selects 16-bit words when 1 and 8-bit words when 0. Bits go out on `mosi` MSB first. An 8-bit word is taken from DATA[7:0], and the upper received byte reads as 0.
- R4: Control bit 7 is the idle level of `sclk`. With control bit 8 = 0, MISO is sampled on the first (leading) edge of each bit and MOSI changes on the trailing edge. With bit 8 = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: With N in control bits 15:9, every `sclk` half-period lasts N+1 clocks, so a W-bit word keeps busy set for exactly 2·W·(N+1) clocks.
- R6: When a word completes, status bit 1 (receive-full) is set and a read of offset 0 returns the received word. A read of offset 0 clears receive-full, but a completion in the same cycle takes priority.
- R7: `irq` = (receive-full AND control bit 5) OR (enable AND NOT busy AND control bit 6).
- R8: Clearing enable in the middle of a word aborts it. Busy drops one clock after the control word changes, `sclk` returns to its idle level and receive-full is not set.
- R9: While no word is being shifted, `mosi` holds its last value.
- R10: Writes honour byte enables: `bus_be[0]` writes bits 7:0 and `bus_be[1]` writes bits 15:8. A data write with only `bus_be[0]` set is an 8-bit access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_rd | input | 1 | Read qualifier for the access (a data read clears receive-full) |
| bus_addr | input | 3 | Byte offset: 0 data, 2 control, 4 status |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an abort in the middle of a word. The enable has to drop while the divider is part way through a half-period, and the stimulus must show that no receive-full is raised and that `sclk` snaps back to the idle level. The bench reaches this case with a long divider and a 16-bit word, and clears enable a few clocks after the launch. A reference model, stepped each clock with the same MISO bit stream, tracks every output, so a sample taken on the wrong edge or a half-period of the wrong length shows up as a mismatch. The four polarity and phase combinations are each run at a different divider setting, and the full divider value is also checked.

// File: rtl/spi_wm_pkg.sv
// Package: shared constants and the control-word layout for the SPI word master.
// Assumes a fixed 16-bit register map addressed by byte offset.
package spi_wm_pkg;
    localparam int WORD_W = 16;
    localparam int DIV_W  = 7;
    localparam int ADDR_W = 3;
    localparam int LANES  = WORD_W / 8;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;

    // Control word, MSB first; positions are fixed by the register map.
    typedef struct packed {
        logic [DIV_W-1:0] div;      // 15:9 half-period count minus one
        logic             cpha;     // 8    phase
        logic             cpol;     // 7    idle level of sclk
        logic             ie_tx;    // 6    ready interrupt enable
        logic             ie_rx;    // 5    receive-full interrupt enable
        logic [1:0]       spare_hi; // 4:3  stored, no function
        logic             wide;     // 2    16-bit words
        logic             spare_lo; // 1    stored, no function
        logic             en;       // 0    enable
    } ctl_t;
endpackage

// File: rtl/spi_wm_regs.sv
// Module: register decode for the SPI word master.
// Holds the control word, decides when a data write launches a word,
// and muxes read data. Assumes single-cycle accesses qualified by bus_sel.
module spi_wm_regs
    import spi_wm_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [W/8-1:0] bus_be,
    input  logic [W-1:0]  bus_wdata,
    input  logic          busy,
    input  logic          rbf,
    input  logic [W-1:0]  rx_data,
    output ctl_t          ctl,
    output logic          launch,
    output logic [W-1:0]  tx_word,
    output logic          rd_clr,
    output logic [W-1:0]  bus_rdata
);
    localparam int NL = W / 8;

    logic [W-1:0] ctl_q;
    logic         wr_data;
    logic         wr_ctrl;

    assign ctl     = ctl_t'(ctl_q);
    assign wr_data = bus_sel & bus_wr & (bus_addr == OFS_DATA);
    assign wr_ctrl = bus_sel & bus_wr & (bus_addr == OFS_CTRL);
    assign rd_clr  = bus_sel & bus_rd & (bus_addr == OFS_DATA);
    assign launch  = wr_data & ctl.en & ~busy;

    // Mask write data by byte lanes to form the outgoing word.
    always_comb begin
        for (int b = 0; b < NL; b++) begin
            tx_word[8*b +: 8] = bus_be[b] ? bus_wdata[8*b +: 8] : 8'h00;
        end
    end

    // Control word storage, written per byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctrl) begin
            for (int b = 0; b < NL; b++) begin
                if (bus_be[b]) ctl_q[8*b +: 8] <= bus_wdata[8*b +: 8];
            end
        end
    end

    // Read-data multiplexer by offset.
    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = rx_data;
            OFS_CTRL: bus_rdata = ctl_q;
            OFS_STAT: bus_rdata = {{(W-2){1'b0}}, rbf, busy};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_wm_clkdiv.sv
// Module: half-period tick generator for the serial clock.
// Emits one tick every DIV+1 clocks while run is high; clr restarts the count.
// Assumes div is held stable while a word is in flight.
module spi_wm_clkdiv #(
    parameter int DW = spi_wm_pkg::DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_q;

    assign tick = run & (cnt_q == div);

    // Count clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_wm_shifter.sv
// Module: shift engine. Drives sclk and mosi, samples miso, holds busy and
// receive-full. One sclk edge is taken per tick; a W-bit word uses 2*W edges.
// Assumes launch is only asserted while enabled and idle.
module spi_wm_shifter #(
    parameter int W = spi_wm_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wide,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         launch,
    input  logic [W-1:0] tx_word,
    input  logic         tick,
    input  logic         miso,
    input  logic         rd_clr,
    output logic         busy,
    output logic         sclk,
    output logic         mosi,
    output logic         rbf,
    output logic [W-1:0] rx_data
);
    localparam int HALF = W / 2;
    localparam int EW   = $clog2(2 * W);
    localparam logic [EW-1:0] LAST_FULL = EW'(2 * W - 1);
    localparam logic [EW-1:0] LAST_HALF = EW'(W - 1);

    logic          busy_q, sclk_q, mosi_q, rbf_q;
    logic [EW-1:0] edge_q;
    logic [W-1:0]  sh_q, rx_q, rxd_q;
    logic [W-1:0]  aligned;
    logic [W-1:0]  rx_next;
    logic          leading, sample, last, done;

    assign aligned = wide ? tx_word : (tx_word << HALF);
    assign leading = ~edge_q[0];
    assign sample  = leading ^ cpha;
    assign last    = (edge_q == (wide ? LAST_FULL : LAST_HALF));
    assign rx_next = sample ? {rx_q[W-2:0], miso} : rx_q;
    assign done    = en & ~launch & busy_q & tick & last;

    assign busy    = busy_q;
    assign sclk    = busy_q ? sclk_q : cpol;
    assign mosi    = mosi_q;
    assign rbf     = rbf_q;
    assign rx_data = rxd_q;

    // Word sequencing: launch, edge stepping, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            edge_q <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            rxd_q  <= '0;
        end else if (!en) begin
            busy_q <= 1'b0;
        end else if (launch) begin
            busy_q <= 1'b1;
            sclk_q <= cpol;
            edge_q <= '0;
            sh_q   <= aligned;
            rx_q   <= '0;
            if (!cpha) mosi_q <= aligned[W-1];
        end else if (busy_q && tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            rx_q   <= rx_next;
            if (cpha && leading) begin
                mosi_q <= sh_q[W-1];
                sh_q   <= sh_q << 1;
            end else if (!cpha && !leading && !last) begin
                mosi_q <= sh_q[W-2];
                sh_q   <= sh_q << 1;
            end
            if (last) begin
                busy_q <= 1'b0;
                rxd_q  <= rx_next;
            end
        end
    end

    // Receive-full flag: set on completion, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rbf_q <= 1'b0;
        else if (done)   rbf_q <= 1'b1;
        else if (rd_clr) rbf_q <= 1'b0;
    end

    // R2: busy only rises on an accepted launch.
    a_r2_busy_from_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(launch));

    // R8: a disabled engine is idle on the next clock.
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy_q);

    // R6: a word that ends while enabled leaves receive-full set.
    a_r6_done_sets_rbf: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && $past(en)) |-> rbf_q);

    // R9: mosi is frozen while idle.
    a_r9_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !launch) |=> $stable(mosi_q));
endmodule

// File: rtl/spi_word_master.sv
// Module: top of the SPI word master. Connects register decode, divider and
// shift engine, and forms the level interrupt. Chip selects are external.
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int DW = DIV_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [W/8-1:0] bus_be,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          irq
);
    ctl_t         ctl;
    logic         launch, rd_clr, busy, rbf, tick;
    logic [W-1:0] tx_word, rx_data;

    spi_wm_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .busy(busy), .rbf(rbf), .rx_data(rx_data),
        .ctl(ctl), .launch(launch), .tx_word(tx_word), .rd_clr(rd_clr),
        .bus_rdata(bus_rdata)
    );

    spi_wm_clkdiv #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .clr(launch),
        .div(ctl.div), .tick(tick)
    );

    spi_wm_shifter #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(ctl.en), .wide(ctl.wide),
        .cpol(ctl.cpol), .cpha(ctl.cpha), .launch(launch), .tx_word(tx_word),
        .tick(tick), .miso(miso), .rd_clr(rd_clr), .busy(busy), .sclk(sclk),
        .mosi(mosi), .rbf(rbf), .rx_data(rx_data)
    );

    // Level interrupt from the two enabled sources.
    assign irq = (rbf & ctl.ie_rx) | (ctl.en & ~busy & ctl.ie_tx);
endmodule

// File: tb/spi_word_master_tb_top.sv
// Bench: behavioural per-clock reference model plus directed checks.
module spi_word_master_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = 0;
    logic [1:0]  bus_be = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, irq;
    logic        miso;
    logic [15:0] lfsr = 16'hACE1;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    spi_word_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pseudo-random MISO stream, changed away from the active edge.
    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign miso = lfsr[0];

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [15:0] m_ctl, m_sh, m_rx, m_rxd;
    logic        m_busy, m_sclk, m_mosi, m_rbf;
    int          m_cnt, m_edges;
    logic [15:0] o_ctl, o_sh, o_rx, wd;
    logic        o_busy, o_sclk, lnch, tk, lead, samp, done_m;
    int          o_cnt, o_edges, wbits, dv;
    logic [15:0] exp_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 0; m_sh = 0; m_rx = 0; m_rxd = 0;
            m_busy = 0; m_sclk = 0; m_mosi = 0; m_rbf = 0;
            m_cnt = 0; m_edges = 0;
        end else begin
            o_ctl = m_ctl; o_sh = m_sh; o_rx = m_rx; o_busy = m_busy;
            o_sclk = m_sclk; o_cnt = m_cnt; o_edges = m_edges;
            wbits = o_ctl[2] ? 16 : 8;
            dv = int'(o_ctl[15:9]);
            wd = {bus_be[1] ? bus_wdata[15:8] : 8'h00, bus_be[0] ? bus_wdata[7:0] : 8'h00};
            lnch = bus_sel && bus_wr && bus_addr == 0 && o_ctl[0] && !o_busy;
            tk = o_busy && (o_cnt == dv);
            done_m = 0;
            if (!o_ctl[0]) begin
                m_busy = 0;
            end else if (lnch) begin
                m_busy = 1; m_edges = 0; m_sclk = o_ctl[7]; m_rx = 0;
                m_sh = (wbits == 16) ? wd : (wd << 8);
                if (!o_ctl[8]) m_mosi = m_sh[15];
            end else if (tk) begin
                lead = (o_edges % 2) == 0;
                samp = o_ctl[8] ? !lead : lead;
                m_sclk = !o_sclk;
                m_edges = o_edges + 1;
                if (samp) m_rx = {o_rx[14:0], miso};
                if (o_ctl[8] && lead) begin m_mosi = o_sh[15]; m_sh = o_sh << 1; end
                if (!o_ctl[8] && !lead && o_edges != 2*wbits-1) begin
                    m_mosi = o_sh[14]; m_sh = o_sh << 1;
                end
                if (o_edges == 2*wbits-1) begin m_busy = 0; m_rxd = m_rx; done_m = 1; end
            end
            if (lnch) m_cnt = 0;
            else if (o_busy) m_cnt = tk ? 0 : o_cnt + 1;
            if (done_m) m_rbf = 1;
            else if (bus_sel && bus_rd && bus_addr == 0) m_rbf = 0;
            if (bus_sel && bus_wr && bus_addr == 2) begin
                if (bus_be[0]) m_ctl[7:0] = bus_wdata[7:0];
                if (bus_be[1]) m_ctl[15:8] = bus_wdata[15:8];
            end
        end
        #2;
        if (rst_n && !finished) begin
            case (bus_addr)
                3'd0: exp_rd = m_rxd;
                3'd2: exp_rd = m_ctl;
                3'd4: exp_rd = {14'b0, m_rbf, m_busy};
                default: exp_rd = 0;
            endcase
            chk("R4 sclk", int'(sclk), int'(m_busy ? m_sclk : m_ctl[7]));
            chk("R3 mosi", int'(mosi), int'(m_mosi));
            chk("R7 irq", int'(irq), int'((m_rbf & m_ctl[5]) | (m_ctl[0] & !m_busy & m_ctl[6])));
            chk("R6 rdata", int'(bus_rdata), int'(exp_rd));
        end
    end

    // Tasks assume they start in the low phase of the clock.
    task automatic bw(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic rd_data(output logic [15:0] v);
        bus_sel = 1; bus_rd = 1; bus_addr = 0; #1; v = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic count_busy(output int n);
        logic [15:0] v;
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            peek(3'd4, v);
            if (!v[0]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R2 watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic        held;
        int          n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        peek(3'd2, v); chk("R1 ctrl", v, 0);
        peek(3'd4, v); chk("R1 stat", v, 0);
        chk("R1 sclk", sclk, 0); chk("R1 irq", irq, 0);
        // R2 data write while disabled is ignored
        bw(3'd0, 16'h00A5, 2'b11);
        repeat (2) @(negedge clk);
        peek(3'd4, v); chk("R2 disabled write", v, 0);
        // R7 ready interrupt; mode 0, 8-bit, N=2
        bw(3'd2, 16'h0461, 2'b11);
        chk("R7 ready irq", irq, 1);
        bw(3'd0, 16'hFF3C, 2'b11);
        count_busy(n); chk("R5 8b N=2 busy clocks", n, 48);
        peek(3'd4, v); chk("R6 rbf set", v, 2);
        chk("R7 rx irq", irq, 1);
        peek(3'd0, v); chk("R3 upper byte zero", v[15:8], 0);
        rd_data(v);
        peek(3'd4, v); chk("R6 rbf cleared", v, 0);
        // Mode 1, 16-bit, N=0, plus an ignored write while busy
        bw(3'd2, 16'h0105, 2'b11);
        bw(3'd0, 16'hBEEF, 2'b11);
        bw(3'd0, 16'h1234, 2'b11);
        count_busy(n); chk("R5 16b N=0 remaining busy", n, 31);
        repeat (3) @(negedge clk);
        peek(3'd4, v); chk("R2 busy write ignored", v, 2);
        rd_data(v);
        // Mode 2, 8-bit, N=1: idle sclk follows polarity
        bw(3'd2, 16'h0281, 2'b11);
        chk("R4 idle high", sclk, 1);
        bw(3'd0, 16'h005A, 2'b01);
        count_busy(n); chk("R5 8b N=1 busy clocks", n, 32);
        chk("R4 idle high after", sclk, 1);
        rd_data(v);
        // Mode 3, 16-bit, N=5
        bw(3'd2, 16'h0B85, 2'b11);
        bw(3'd0, 16'hC3A1, 2'b11);
        count_busy(n); chk("R5 16b N=5 busy clocks", n, 192);
        rd_data(v);
        // R9 mosi holds while idle, even across a control write
        held = mosi;
        bw(3'd2, 16'h0B05, 2'b11);
        repeat (20) @(negedge clk);
        chk("R9 mosi held", mosi, held);
        // R5 largest divider
        bw(3'd2, 16'hFE01, 2'b11);
        bw(3'd0, 16'h0081, 2'b11);
        count_busy(n); chk("R5 N=127 busy clocks", n, 2048);
        rd_data(v);
        // R8 abort mid-word
        bw(3'd2, 16'h0E05, 2'b11);
        bw(3'd0, 16'h7E81, 2'b11);
        repeat (10) @(negedge clk);
        bw(3'd2, 16'h0E04, 2'b11);
        peek(3'd4, v); chk("R8 still busy one clock", v, 1);
        @(negedge clk);
        peek(3'd4, v); chk("R8 aborted idle no rbf", v, 0);
        chk("R8 sclk idle", sclk, 0);
        repeat (300) @(negedge clk);
        peek(3'd4, v); chk("R8 no late rbf", v, 0);
        // R10 byte lanes on the control word
        bw(3'd2, 16'hFFFF, 2'b10);
        peek(3'd2, v); chk("R10 upper lane only", v, 16'hFF04);
        bw(3'd2, 16'h0041, 2'b01);
        peek(3'd2, v); chk("R10 lower lane only", v, 16'hFF41);
        chk("R7 ready irq en", irq, 1);
        bw(3'd2, 16'h0001, 2'b11);
        chk("R7 ready irq masked", irq, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule